// File: doc/BRIEF.md
# ADC Result Capture with Compare

This block sits between a converter core and a byte-wide register bus. Whenever the converter pulses its done strobe with a fresh 10-bit value, the block can place that value into a pair of byte registers, a high byte and a low byte. An optional automatic compare gates that capture. Software turns it on and picks a direction. The block then keeps only results that fall below a programmable level, or only results that reach or exceed it. Only results that are actually captured raise a completion flag.

Two result widths are supported. In the wide (10-bit) mode the top two result bits go to the high byte. A read of the high byte freezes the pair until the matching low-byte read, so software always gets both halves of the same sample. Conversions that finish while the pair is frozen are thrown away, not held back. In the narrow (8-bit) mode the low byte carries the whole result, the high byte stays zero, and there is no freezing. Any change of mode wipes the pair, since its contents no longer match the layout.

Top module: `adc_result_capture`

## Requirements
- R1: With `cmp_en`=0, every `conv_done` pulse that is not blocked (R6) and not in a mode-change cycle (R9) updates the pair on the next clock edge and sets `done_flag`.
- R2: With `cmp_en`=1 and `cmp_ge`=0 a conversion qualifies only if its value is strictly less than the compare level. With `cmp_ge`=1 it qualifies only if its value is greater than or equal to the level. Values are compared as unsigned numbers.
- R3: A conversion that does not qualify leaves `res_hi`, `res_lo` and `done_flag` unchanged.
- R4: In wide mode (`mode_10b`=1) a stored result shows bits 9:8 of `conv_data` in `res_hi` bits 1:0, and bits 7:2 of `res_hi` are always 0. `res_lo` holds `conv_data` bits 7:0.
- R5: In narrow mode (`mode_10b`=0) `res_lo` holds `conv_data` bits 7:0, bits 9:8 of `conv_data` are ignored, and `res_hi` reads 0.
- R6: In wide mode no store happens in a cycle where `rd_hi` is high. `lock_active` goes high on the next edge, and no store happens in any later cycle until the cycle in which `rd_lo` is high. A conversion in that `rd_lo` cycle is stored, and `lock_active` falls on the edge that ends that cycle.
- R7: A conversion blocked by the lock is discarded and never appears in the pair later.
- R8: In narrow mode `rd_hi` has no effect, `lock_active` stays 0 and every qualifying conversion is stored at once.
- R9: In a cycle where `mode_10b` differs from its value in the previous cycle, the pair, `done_flag` and the lock are all cleared on the next edge, and any conversion in that cycle is discarded.
- R10: `done_flag` is set only by a store. It is cleared by `rd_lo` unless a store happens in the same cycle, in which case it stays set.
- R11: The compare level is 10 bits wide. In narrow mode only bits 7:0 of the level and bits 7:0 of the data are compared.
- R12: While `rst_n` is low at a clock edge, the pair, the lock and `done_flag` are cleared, and the mode history takes the current `mode_10b`, so the first cycle after reset is not a mode change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_done | input | 1 | One-cycle pulse: a conversion finished |
| conv_data | input | 10 | Value of the finished conversion |
| mode_10b | input | 1 | 1 = wide (10-bit) mode, 0 = narrow (8-bit) mode |
| cmp_en | input | 1 | Enables the automatic compare |
| cmp_ge | input | 1 | Compare direction: 0 = less than, 1 = greater or equal |
| cmp_level | input | 10 | Compare level |
| rd_hi | input | 1 | Read strobe for the high result byte |
| rd_lo | input | 1 | Read strobe for the low result byte |
| res_hi | output | 8 | High result byte |
| res_lo | output | 8 | Low result byte |
| done_flag | output | 1 | A result has been stored and not yet read |
| lock_active | output | 1 | Pair frozen after a high-byte read (wide mode) |

## Verification
The bound assertions check on every cycle that the unused high-byte bits stay zero and that the high byte reads zero in narrow mode. They also check that a frozen pair holds steady, that a failed compare in wide mode leaves the pair untouched, and that a mode change zeroes everything. In addition they cover the flag's set and clear rules, narrow mode never locking, and the reset values. Some behaviours need scenarios from the bench's scoreboard. These include the exact byte layout of stored values, both compare directions right at the boundary, and the narrow compare ignoring the level's upper bits. The bench scenarios also show that blocked conversions are lost rather than delivered late, and that a conversion in the low-read cycle is kept.

// File: rtl/adc_rc_pkg.sv
// Package: shared types for the ADC result capture block.
// Assumes: result width never exceeds two bytes.
package adc_rc_pkg;

    // Result layout selected by software.
    typedef enum logic {
        RES_NARROW = 1'b0,
        RES_WIDE   = 1'b1
    } res_mode_e;

endpackage

// File: rtl/adc_rc_compare.sv
// Module: adc_rc_compare
// Decides whether a finished conversion qualifies for storage.
// Assumes: unsigned values; in narrow mode only the low BYTE_W bits of
// data and level take part. With the compare off every value qualifies.
module adc_rc_compare
    import adc_rc_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic [RES_W-1:0] conv_data,
    input  logic [RES_W-1:0] cmp_level,
    input  res_mode_e        mode,
    input  logic             cmp_en,
    input  logic             cmp_ge,
    output logic             hit
);

    localparam int PAD_W = RES_W - BYTE_W;
    localparam logic [RES_W-1:0] NARROW_MASK = {{PAD_W{1'b0}}, {BYTE_W{1'b1}}};

    logic [RES_W-1:0] mask;
    logic [RES_W-1:0] val_m;
    logic [RES_W-1:0] lvl_m;
    logic             below;

    // Purpose: strip the bits that the current mode does not compare.
    always_comb begin
        mask  = (mode == RES_WIDE) ? {RES_W{1'b1}} : NARROW_MASK;
        val_m = conv_data & mask;
        lvl_m = cmp_level & mask;
    end

    // Purpose: evaluate the selected direction and the enable.
    always_comb begin
        below = (val_m < lvl_m);
        if (!cmp_en)
            hit = 1'b1;
        else if (cmp_ge)
            hit = !below;
        else
            hit = below;
    end

endmodule

// File: rtl/adc_rc_lock.sv
// Module: adc_rc_lock
// Tracks the mode history and the high/low read coherency lock.
// Assumes: read strobes are single-cycle; the lock exists only in wide
// mode; a mode change clears the lock on the following edge.
module adc_rc_lock
    import adc_rc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  res_mode_e mode,
    input  logic      rd_hi,
    input  logic      rd_lo,
    output logic      mode_chg,
    output logic      block,
    output logic      lock_q
);

    res_mode_e mode_q;
    logic      wide;

    // Purpose: remember last cycle's mode; during reset follow the input.
    always_ff @(posedge clk) begin
        mode_q <= mode;
    end

    // Purpose: derive mode-change and store-block conditions.
    always_comb begin
        wide     = (mode == RES_WIDE);
        mode_chg = (mode != mode_q);
        block    = wide && (rd_hi || (lock_q && !rd_lo));
    end

    // Purpose: set the lock on a high read, release it on a low read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= 1'b0;
        else if (mode_chg || !wide || rd_lo)
            lock_q <= 1'b0;
        else if (rd_hi)
            lock_q <= 1'b1;
    end

endmodule

// File: rtl/adc_rc_store.sv
// Module: adc_rc_store
// Holds the result byte pair and the completion flag.
// Assumes: RES_W > BYTE_W and RES_W <= 2*BYTE_W; wr_en and clr never
// both act in one cycle (clr wins if they do).
module adc_rc_store
    import adc_rc_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              clr,
    input  res_mode_e         mode,
    input  logic [RES_W-1:0]  conv_data,
    input  logic              rd_lo,
    output logic [BYTE_W-1:0] res_hi,
    output logic [BYTE_W-1:0] res_lo,
    output logic              done_flag
);

    localparam int HI_BITS = RES_W - BYTE_W;

    logic [HI_BITS-1:0] hi_q;
    logic [BYTE_W-1:0]  lo_q;
    logic               flag_q;

    // Purpose: capture the result in the layout of the current mode.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (wr_en) begin
            hi_q <= (mode == RES_WIDE) ? conv_data[RES_W-1:BYTE_W] : '0;
            lo_q <= conv_data[BYTE_W-1:0];
        end
    end

    // Purpose: flag a stored result until the low byte is read.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            flag_q <= 1'b0;
        else if (wr_en)
            flag_q <= 1'b1;
        else if (rd_lo)
            flag_q <= 1'b0;
    end

    // Purpose: pad the high byte with zeros above the stored bits.
    generate
        if (HI_BITS < BYTE_W) begin : g_pad
            assign res_hi = {{(BYTE_W-HI_BITS){1'b0}}, hi_q};
        end else begin : g_full
            assign res_hi = hi_q;
        end
    endgenerate

    assign res_lo    = lo_q;
    assign done_flag = flag_q;

endmodule

// File: rtl/adc_result_capture.sv
// Module: adc_result_capture (top)
// Captures finished conversions into a high/low result pair, gated by an
// optional compare and by the wide-mode read lock.
// Assumes: conv_done, rd_hi and rd_lo are single-cycle strobes in clk.
module adc_result_capture
    import adc_rc_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_data,
    input  logic              mode_10b,
    input  logic              cmp_en,
    input  logic              cmp_ge,
    input  logic [RES_W-1:0]  cmp_level,
    input  logic              rd_hi,
    input  logic              rd_lo,
    output logic [BYTE_W-1:0] res_hi,
    output logic [BYTE_W-1:0] res_lo,
    output logic              done_flag,
    output logic              lock_active
);

    res_mode_e mode;
    logic      hit;
    logic      mode_chg;
    logic      block;
    logic      wr_en;

    // Purpose: map the mode pin onto the shared enum.
    always_comb begin
        mode = mode_10b ? RES_WIDE : RES_NARROW;
    end

    adc_rc_compare #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_cmp (
        .conv_data (conv_data),
        .cmp_level (cmp_level),
        .mode      (mode),
        .cmp_en    (cmp_en),
        .cmp_ge    (cmp_ge),
        .hit       (hit)
    );

    adc_rc_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .rd_hi    (rd_hi),
        .rd_lo    (rd_lo),
        .mode_chg (mode_chg),
        .block    (block),
        .lock_q   (lock_active)
    );

    // Purpose: a conversion is stored when it qualifies and nothing blocks it.
    always_comb begin
        wr_en = conv_done && hit && !block && !mode_chg;
    end

    adc_rc_store #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .clr       (mode_chg),
        .mode      (mode),
        .conv_data (conv_data),
        .rd_lo     (rd_lo),
        .res_hi    (res_hi),
        .res_lo    (res_lo),
        .done_flag (done_flag)
    );

endmodule

// File: rtl/adc_rc_checker.sv
// Module: adc_rc_checker
// Port-level properties of adc_result_capture, attached by bind.
module adc_rc_checker #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_done,
    input logic [RES_W-1:0]  conv_data,
    input logic              mode_10b,
    input logic              cmp_en,
    input logic              cmp_ge,
    input logic [RES_W-1:0]  cmp_level,
    input logic              rd_hi,
    input logic              rd_lo,
    input logic [BYTE_W-1:0] res_hi,
    input logic [BYTE_W-1:0] res_lo,
    input logic              done_flag,
    input logic              lock_active
);

    localparam int HI_BITS = RES_W - BYTE_W;

    AST_HI_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        res_hi[BYTE_W-1:HI_BITS] == '0); // R4

    AST_MISS_KEEPS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && cmp_en && mode_10b && $past(mode_10b) &&
         ((cmp_ge && conv_data < cmp_level) || (!cmp_ge && conv_data >= cmp_level)))
        |=> ($stable(res_lo) && $stable(res_hi))); // R3

    AST_NARROW_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_10b && !$past(mode_10b)) |-> (res_hi == '0)); // R5

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_active && !rd_lo && mode_10b && $past(mode_10b))
        |=> ($stable(res_lo) && $stable(res_hi))); // R6

    AST_NARROW_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_10b && !$past(mode_10b)) |-> !lock_active); // R8

    AST_MODE_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_10b != $past(mode_10b))
        |=> (res_hi == '0 && res_lo == '0 && !lock_active && !done_flag)); // R9

    AST_FLAG_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !conv_done) |=> !done_flag); // R10

    AST_FLAG_ONLY_ON_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(conv_done)); // R10

    AST_NARROW_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi && !mode_10b) |=> !lock_active); // R8

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (res_hi == '0 && res_lo == '0 && !lock_active && !done_flag)); // R12

endmodule

bind adc_result_capture adc_rc_checker #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_done   (conv_done),
    .conv_data   (conv_data),
    .mode_10b    (mode_10b),
    .cmp_en      (cmp_en),
    .cmp_ge      (cmp_ge),
    .cmp_level   (cmp_level),
    .rd_hi       (rd_hi),
    .rd_lo       (rd_lo),
    .res_hi      (res_hi),
    .res_lo      (res_lo),
    .done_flag   (done_flag),
    .lock_active (lock_active)
);

// File: tb/adc_result_capture_test.sv
`timescale 1ns/1ps
module adc_result_capture_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_done = 1'b0;
    logic [9:0] conv_data = '0;
    logic       mode_10b = 1'b1;
    logic       cmp_en = 1'b0;
    logic       cmp_ge = 1'b0;
    logic [9:0] cmp_level = '0;
    logic       rd_hi = 1'b0;
    logic       rd_lo = 1'b0;
    logic [7:0] res_hi;
    logic [7:0] res_lo;
    logic       done_flag;
    logic       lock_active;

    int total = 0;
    int bad = 0;
    bit done_run = 1'b0;

    typedef struct {
        logic [7:0] hi;
        logic [7:0] lo;
        logic       flag;
        logic       lock;
        string      tag;
    } exp_t;

    exp_t sb[$];

    // model state
    logic [7:0] m_hi = '0;
    logic [7:0] m_lo = '0;
    logic       m_flag = 1'b0;
    logic       m_lock = 1'b0;
    logic       m_mode = 1'b1;

    always #2 clk = ~clk;

    adc_result_capture uut (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
        .mode_10b(mode_10b), .cmp_en(cmp_en), .cmp_ge(cmp_ge), .cmp_level(cmp_level),
        .rd_hi(rd_hi), .rd_lo(rd_lo), .res_hi(res_hi), .res_lo(res_lo),
        .done_flag(done_flag), .lock_active(lock_active)
    );

    // One cycle of stimulus; the expected state after the edge goes to the scoreboard.
    task automatic step(input logic cv, input logic [9:0] d, input logic rh,
                        input logic rl, input string tag);
        logic hit;
        logic [9:0] va;
        logic [9:0] lv;
        logic blk;
        logic st;
        @(negedge clk);
        conv_done = cv; conv_data = d; rd_hi = rh; rd_lo = rl;
        va = mode_10b ? d : {2'b00, d[7:0]};
        lv = mode_10b ? cmp_level : {2'b00, cmp_level[7:0]};
        hit = !cmp_en || (cmp_ge ? (va >= lv) : (va < lv));
        blk = mode_10b && (rh || (m_lock && !rl));
        if (mode_10b != m_mode) begin
            m_hi = '0; m_lo = '0; m_flag = 1'b0; m_lock = 1'b0;
        end else begin
            st = cv && hit && !blk;
            if (st) begin
                m_hi = mode_10b ? {6'b0, d[9:8]} : 8'h00;
                m_lo = d[7:0];
            end
            if (st) m_flag = 1'b1;
            else if (rl) m_flag = 1'b0;
            if (!mode_10b || rl) m_lock = 1'b0;
            else if (rh) m_lock = 1'b1;
        end
        m_mode = mode_10b;
        @(posedge clk);
        #1;
        sb.push_back('{m_hi, m_lo, m_flag, m_lock, tag});
        conv_done = 1'b0; rd_hi = 1'b0; rd_lo = 1'b0;
    endtask

    // Monitor: pops expectations and compares against outputs.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (res_hi !== e.hi || res_lo !== e.lo || done_flag !== e.flag ||
                lock_active !== e.lock) begin
                bad++;
                $display("FAIL %s: got hi=%02h lo=%02h flag=%0b lock=%0b exp hi=%02h lo=%02h flag=%0b lock=%0b",
                         e.tag, res_hi, res_lo, done_flag, lock_active,
                         e.hi, e.lo, e.flag, e.lock);
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done_run) begin
            total++; bad++;
            $display("FAIL watchdog: got running exp finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state, no mode change seen after reset
        total++;
        if (res_hi !== 8'h00 || res_lo !== 8'h00 || done_flag !== 1'b0 || lock_active !== 1'b0) begin
            bad++;
            $display("FAIL R12 reset: got hi=%02h lo=%02h flag=%0b lock=%0b exp 00 00 0 0",
                     res_hi, res_lo, done_flag, lock_active);
        end
        step(1'b1, 10'h3A5, 1'b0, 1'b0, "R12_first_cycle_stores");

        // R1, R4: compare off, wide layout
        step(1'b1, 10'h001, 1'b0, 1'b0, "R1_store_001");
        step(1'b1, 10'h3FF, 1'b0, 1'b0, "R4_store_3FF");
        step(1'b0, 10'h000, 1'b0, 1'b1, "R10_read_clears_flag");
        step(1'b1, 10'h2C7, 1'b0, 1'b0, "R4_store_2C7");

        // R2, R3: less-than direction at the boundary
        cmp_en = 1'b1; cmp_ge = 1'b0; cmp_level = 10'h200;
        step(1'b0, 10'h000, 1'b0, 1'b1, "R10_clear_flag");
        step(1'b1, 10'h200, 1'b0, 1'b0, "R3_lt_equal_miss");
        step(1'b1, 10'h3FF, 1'b0, 1'b0, "R3_lt_above_miss");
        step(1'b1, 10'h1FF, 1'b0, 1'b0, "R2_lt_below_hit");
        // greater-or-equal direction
        cmp_ge = 1'b1;
        step(1'b1, 10'h1FF, 1'b0, 1'b0, "R3_ge_below_miss");
        step(1'b1, 10'h200, 1'b0, 1'b0, "R2_ge_equal_hit");
        cmp_en = 1'b0;

        // R6, R7: lock between high and low reads
        step(1'b1, 10'h155, 1'b1, 1'b0, "R6_block_in_rdhi_cycle");
        step(1'b1, 10'h0AA, 1'b0, 1'b0, "R7_blocked_discarded");
        step(1'b0, 10'h000, 1'b0, 1'b0, "R7_not_delivered_late");
        step(1'b1, 10'h111, 1'b0, 1'b1, "R6_store_in_rdlo_cycle");
        step(1'b1, 10'h123, 1'b0, 1'b0, "R6_unlocked_store");
        step(1'b1, 10'h0F0, 1'b1, 1'b1, "R10_rd_both_no_store");

        // R9: mode change with lock held and conversion in that cycle
        step(1'b0, 10'h000, 1'b1, 1'b0, "R6_lock_again");
        mode_10b = 1'b0;
        step(1'b1, 10'h3C3, 1'b0, 1'b0, "R9_change_clears_discards");

        // R5, R8: narrow mode, no lock
        step(1'b1, 10'h3C3, 1'b0, 1'b0, "R5_narrow_store");
        step(1'b1, 10'h2A5, 1'b1, 1'b0, "R8_rdhi_no_block");
        step(1'b1, 10'h17E, 1'b0, 1'b0, "R8_no_lock_store");

        // R11: narrow compare uses low level bits only (level 0x305 -> 0x05)
        cmp_en = 1'b1; cmp_ge = 1'b1; cmp_level = 10'h305;
        step(1'b1, 10'h004, 1'b0, 1'b0, "R11_narrow_miss");
        step(1'b1, 10'h006, 1'b0, 1'b0, "R11_narrow_hit");
        step(1'b1, 10'h305, 1'b0, 1'b1, "R10_store_beats_read");
        cmp_en = 1'b0;

        // R9: back to wide clears pair
        mode_10b = 1'b1;
        step(1'b0, 10'h000, 1'b0, 1'b0, "R9_back_to_wide");
        step(1'b1, 10'h2E1, 1'b0, 1'b0, "R1_wide_again");

        repeat (3) @(posedge clk);
        done_run = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule